// File: doc/BRIEF.md
# Extended Arithmetic Instruction Sequencer

This block sits beside a 16-bit accumulator CPU. It decodes instructions meant for an extended arithmetic unit and runs them on the A and B accumulators. The CPU pulses `start_i` with the instruction word, both accumulators, the overflow bit, and the two memory words the instruction may need. The CPU also supplies an effective address, a flag that says the unit is fitted, and a flag that selects the newer CPU model. When the work is finished the block raises a single-cycle `done_o` together with the new A, B and overflow values. In the same cycle it may pulse one of three strobes: a two-word store request, a request to re-execute the instruction, or a report that the code is undefined.

Bits 15:8 of the word choose a group and bits 7:4 choose a sub-operation inside the two shift groups. Bits 3:0 give a shift count. A separate shifter and an iterative divider do the long datapath work, and the sequencer starts each one with a pulse and waits for its done. Multiply, double load, double store and the counting delay instruction finish in the first execute cycle. One code changes meaning with the model flag. On the newer model it is a self-repeating counter; on the older model it falls through to multiply. Address generation, indirection and memory access belong to the CPU.

Top module: `xarith_ctrl`

## Requirements
- R1: With `present_i` low, every instruction completes with `a_o`, `b_o` and `ovf_o` equal to the inputs and no store, repeat or undefined strobe.
- R2: Bits 3:0 give the shift count, and a field of 0 means a count of 16. The operand is the 32-bit value with B in the high half and A in the low half.
- R3: Group octal 200 performs left shifts. Sub-op 1 is an arithmetic shift that keeps bit 31 and sets overflow when any bit shifted past bit 30 differs from the sign, otherwise clears it. Sub-op 2 is a logical shift and sub-op 4 is a rotate, and both leave overflow unchanged.
- R4: Group octal 202 performs right shifts. Sub-op 1 is arithmetic (sign fill) and clears overflow. Sub-op 2 is logical (zero fill) and sub-op 4 is a rotate, and both leave overflow unchanged.
- R5: Group 200 sub-op octal 10 multiplies A by the memory word as signed 16-bit values. The 32-bit product goes to B (high) and A (low), and overflow is cleared.
- R6: Group 201 divides the signed 32-bit B:A by the signed memory word. The quotient goes to A and the remainder, carrying the dividend's sign, goes to B. Overflow is set when the signed quotient does not fit in 16 bits.
- R7: When the magnitude of B is not below the divisor magnitude, which includes a zero divisor, the divide sets overflow and leaves A and B unchanged.
- R8: Group 210 loads A from memory word 0 and B from memory word 1, and leaves overflow unchanged.
- R9: Group 211 pulses `store_o`, writing A to `addr_i` and B to `addr_i`+1 with the address wrapping within 15 bits. Registers are unchanged.
- R10: With `newer_i` high, group 200 sub-op 3 sets B to B+1 modulo 2^16. It pulses `repeat_o` unless the new B is zero, and leaves A and overflow unchanged.
- R11: With `newer_i` low, group 200 sub-op 3 executes as the multiply of R5.
- R12: Group 200 sub-op 0 is a no-op on the newer model. Every other undefined sub-op, that code on the older model, and any group other than 200, 201, 202, 210 and 211 pulse `undef_o` and leave A, B and overflow unchanged.
- R13: `done_o` is high for exactly one cycle per started instruction, and every strobe is high only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction; sampled while idle |
| instr_i | input | 16 | Instruction word |
| a_i | input | 16 | A accumulator |
| b_i | input | 16 | B accumulator |
| mem0_i | input | 16 | Memory operand word |
| mem1_i | input | 16 | Second memory word (double load) |
| addr_i | input | 15 | Effective address (double store) |
| ovf_i | input | 1 | Current overflow bit |
| present_i | input | 1 | Unit fitted |
| newer_i | input | 1 | Newer CPU model selected |
| done_o | output | 1 | Completion pulse |
| a_o | output | 16 | New A value |
| b_o | output | 16 | New B value |
| ovf_o | output | 1 | New overflow bit |
| repeat_o | output | 1 | Re-execute the instruction |
| undef_o | output | 1 | Undefined instruction |
| store_o | output | 1 | Two-word store request |
| st_addr0_o | output | 15 | First store address |
| st_data0_o | output | 16 | First store word (A) |
| st_addr1_o | output | 15 | Second store address |
| st_data1_o | output | 16 | Second store word (B) |

## Verification
The counting delay instruction raises `done_o` and `repeat_o` in the same cycle. The bench provokes this by running that code on the newer model with B swept through 0, 1, 0x7FFF, 0xFFFE and 0xFFFF. It then checks that the repeat pulse coincides with completion and that it drops exactly when B wraps to zero. The same code on the older model must instead yield a product and no repeat. A second collision is the undefined report against the fitted flag: undefined codes are sent with `present_i` low, and no strobe may appear then.

// File: rtl/xa_pkg.sv
package xa_pkg;
  parameter int XA_W  = 16;
  parameter int XA_AW = 15;
  localparam int XA_IW = 16;

  localparam logic [7:0] GRP_LSH = 8'o200;
  localparam logic [7:0] GRP_DIV = 8'o201;
  localparam logic [7:0] GRP_RSH = 8'o202;
  localparam logic [7:0] GRP_DLD = 8'o210;
  localparam logic [7:0] GRP_DST = 8'o211;

  localparam logic [3:0] SUB_SELF = 4'o00;
  localparam logic [3:0] SUB_ASH  = 4'o01;
  localparam logic [3:0] SUB_LGC  = 4'o02;
  localparam logic [3:0] SUB_TMR  = 4'o03;
  localparam logic [3:0] SUB_ROT  = 4'o04;
  localparam logic [3:0] SUB_MPY  = 4'o10;

  typedef enum logic [3:0] {
    OP_NOP, OP_UNDEF, OP_ASL, OP_LSL, OP_RRL, OP_ASR, OP_LSR, OP_RRR,
    OP_MPY, OP_DIV, OP_DLD, OP_DST, OP_TMR
  } xa_op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_SHW, ST_DVW} xa_st_e;
endpackage

// File: rtl/xa_decode.sv
module xa_decode
  import xa_pkg::*;
#(
  parameter int W  = XA_W,
  localparam int FW = $clog2(W),
  localparam int CW = FW + 1
) (
  input  logic [XA_IW-1:0] instr_i,
  input  logic             newer_i,
  output xa_op_e           op_o,
  output logic [CW-1:0]    cnt_o
);
  logic [7:0] grp;
  logic [3:0] sub;

  assign grp   = instr_i[15:8];
  assign sub   = instr_i[7:4];
  // zero count field encodes the full word width
  assign cnt_o = (instr_i[FW-1:0] == '0) ? CW'(W) : {1'b0, instr_i[FW-1:0]};

  always_comb begin
    op_o = OP_UNDEF;
    unique case (grp)
      GRP_LSH: begin
        unique case (sub)
          SUB_SELF: op_o = newer_i ? OP_NOP : OP_UNDEF;
          SUB_ASH:  op_o = OP_ASL;
          SUB_LGC:  op_o = OP_LSL;
          SUB_TMR:  op_o = newer_i ? OP_TMR : OP_MPY;
          SUB_ROT:  op_o = OP_RRL;
          SUB_MPY:  op_o = OP_MPY;
          default:  op_o = OP_UNDEF;
        endcase
      end
      GRP_RSH: begin
        unique case (sub)
          SUB_ASH: op_o = OP_ASR;
          SUB_LGC: op_o = OP_LSR;
          SUB_ROT: op_o = OP_RRR;
          default: op_o = OP_UNDEF;
        endcase
      end
      GRP_DIV: op_o = OP_DIV;
      GRP_DLD: op_o = OP_DLD;
      GRP_DST: op_o = OP_DST;
      default: op_o = OP_UNDEF;
    endcase
  end
endmodule

// File: rtl/xa_shift.sv
module xa_shift
  import xa_pkg::*;
#(
  parameter int W  = XA_W,
  localparam int DW = 2 * W,
  localparam int CW = $clog2(W) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  xa_op_e        kind_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] opnd_i,
  output logic          done_o,
  output logic [DW-1:0] res_o,
  output logic          ovf_o
);
  logic [DW-1:0]   shl, shr, sar, res_d;
  logic [2*DW-1:0] rol_w, ror_w, lost_w;
  logic [DW-1:0]   lost_src;
  logic            asl_ovf;

  always_comb begin
    shl   = opnd_i << cnt_i;
    shr   = opnd_i >> cnt_i;
    sar   = DW'($signed(opnd_i) >>> cnt_i);
    rol_w = {opnd_i, opnd_i} << cnt_i;
    ror_w = {opnd_i, opnd_i} >> cnt_i;
    // magnitude bits compared with the sign; those leaving bit DW-2 are lost
    lost_src = {1'b0, opnd_i[DW-1] ? ~opnd_i[DW-2:0] : opnd_i[DW-2:0]};
    lost_w   = {{DW{1'b0}}, lost_src} << cnt_i;
    asl_ovf  = |lost_w[2*DW-1:DW-1];
    unique case (kind_i)
      OP_ASL:  res_d = {opnd_i[DW-1], shl[DW-2:0]};
      OP_LSL:  res_d = shl;
      OP_RRL:  res_d = rol_w[2*DW-1:DW];
      OP_ASR:  res_d = sar;
      OP_LSR:  res_d = shr;
      OP_RRR:  res_d = ror_w[DW-1:0];
      default: res_d = opnd_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      res_o  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        res_o <= res_d;
        ovf_o <= asl_ovf;
      end
    end
  end

  AST_SH_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
  AST_SH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_i >= CW'(1) && cnt_i <= CW'(W))); // R2
endmodule

// File: rtl/xa_div.sv
module xa_div
  import xa_pkg::*;
#(
  parameter int W  = XA_W,
  localparam int DW = 2 * W,
  localparam int KW = $clog2(W) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [W-1:0]  dvs_i,
  output logic          done_o,
  output logic [W-1:0]  quo_o,
  output logic [W-1:0]  rem_o
);
  logic [W-1:0]  part, low, dvs_r;
  logic [KW-1:0] left;
  logic          busy;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  part_n;

  assign quo_o = low;
  assign rem_o = part;

  always_comb begin
    trial  = {part, low[W-1]};
    fits   = trial >= {1'b0, dvs_r};
    part_n = fits ? W'(trial - {1'b0, dvs_r}) : trial[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part   <= '0;
      low    <= '0;
      dvs_r  <= '0;
      left   <= '0;
      busy   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy) begin
        // caller guarantees the high half is below the divisor
        part  <= dvd_i[DW-1:W];
        low   <= dvd_i[W-1:0];
        dvs_r <= dvs_i;
        left  <= KW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        part <= part_n;
        low  <= {low[W-2:0], fits};
        left <= left - KW'(1);
        if (left == KW'(1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_o < dvs_r)); // R6
  AST_DV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
endmodule

// File: rtl/xarith_ctrl.sv
module xarith_ctrl
  import xa_pkg::*;
#(
  parameter int W  = XA_W,
  parameter int AW = XA_AW,
  localparam int DW = 2 * W,
  localparam int CW = $clog2(W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XA_IW-1:0] instr_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     mem0_i,
  input  logic [W-1:0]     mem1_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             ovf_i,
  input  logic             present_i,
  input  logic             newer_i,
  output logic             done_o,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o,
  output logic             ovf_o,
  output logic             repeat_o,
  output logic             undef_o,
  output logic             store_o,
  output logic [AW-1:0]    st_addr0_o,
  output logic [W-1:0]     st_data0_o,
  output logic [AW-1:0]    st_addr1_o,
  output logic [W-1:0]     st_data1_o
);
  xa_st_e           state;
  logic [XA_IW-1:0] c_instr;
  logic [W-1:0]     c_a, c_b, c_m0, c_m1;
  logic [AW-1:0]    c_addr;
  logic             c_ovf, c_present, c_newer;

  xa_op_e        dec_op, op;
  logic [CW-1:0] dec_cnt;

  xa_decode #(.W(W)) u_dec (
    .instr_i(c_instr), .newer_i(c_newer), .op_o(dec_op), .cnt_o(dec_cnt)
  );
  assign op = c_present ? dec_op : OP_NOP;

  // shifter
  logic          sh_go, sh_done, sh_ovf;
  logic [DW-1:0] sh_res;
  xa_shift #(.W(W)) u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sh_go), .kind_i(op),
    .cnt_i(dec_cnt), .opnd_i({c_b, c_a}), .done_o(sh_done),
    .res_o(sh_res), .ovf_o(sh_ovf)
  );

  // divide: sign handling around an unsigned core
  logic          rs, qs, pre_ovf, dv_go, dv_done, q_ovf;
  logic [DW-1:0] dvd, dvd_mag;
  logic [W-1:0]  dvs_mag, dv_q, dv_r, q_sgn, r_sgn;

  always_comb begin
    rs      = c_b[W-1];
    qs      = rs ^ c_m0[W-1];
    dvd     = {c_b, c_a};
    dvd_mag = rs ? (~dvd + DW'(1)) : dvd;
    dvs_mag = c_m0[W-1] ? (~c_m0 + W'(1)) : c_m0;
    pre_ovf = dvd_mag[DW-1:W] >= dvs_mag;
    q_sgn   = qs ? (~dv_q + W'(1)) : dv_q;
    q_ovf   = (dv_q != '0) && (q_sgn[W-1] ^ qs);
    r_sgn   = rs ? (~dv_r + W'(1)) : dv_r;
  end

  xa_div #(.W(W)) u_dv (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dv_go), .dvd_i(dvd_mag),
    .dvs_i(dvs_mag), .done_o(dv_done), .quo_o(dv_q), .rem_o(dv_r)
  );

  logic [DW-1:0] prod;
  logic [W-1:0]  b_inc;
  assign prod  = $signed({{W{c_a[W-1]}}, c_a}) * $signed({{W{c_m0[W-1]}}, c_m0});
  assign b_inc = c_b + W'(1);

  // completion values
  logic         fin, n_ovf, n_store, n_rep, n_undef;
  logic [W-1:0] n_a, n_b;
  xa_st_e       n_state;

  always_comb begin
    fin     = 1'b0;
    n_a     = c_a;
    n_b     = c_b;
    n_ovf   = c_ovf;
    n_store = 1'b0;
    n_rep   = 1'b0;
    n_undef = 1'b0;
    sh_go   = 1'b0;
    dv_go   = 1'b0;
    n_state = state;
    unique case (state)
      ST_IDLE: if (start_i) n_state = ST_EXEC;
      ST_EXEC: begin
        unique case (op)
          OP_NOP:   fin = 1'b1;
          OP_UNDEF: begin fin = 1'b1; n_undef = 1'b1; end
          OP_ASL, OP_LSL, OP_RRL, OP_ASR, OP_LSR, OP_RRR: begin
            sh_go   = 1'b1;
            n_state = ST_SHW;
          end
          OP_MPY: begin
            fin   = 1'b1;
            n_b   = prod[DW-1:W];
            n_a   = prod[W-1:0];
            n_ovf = 1'b0;
          end
          OP_DIV: begin
            if (pre_ovf) begin
              fin   = 1'b1;
              n_ovf = 1'b1;
            end else begin
              dv_go   = 1'b1;
              n_state = ST_DVW;
            end
          end
          OP_DLD: begin fin = 1'b1; n_a = c_m0; n_b = c_m1; end
          OP_DST: begin fin = 1'b1; n_store = 1'b1; end
          OP_TMR: begin
            fin   = 1'b1;
            n_b   = b_inc;
            n_rep = (b_inc != '0);
          end
          default: fin = 1'b1;
        endcase
      end
      ST_SHW: if (sh_done) begin
        fin = 1'b1;
        {n_b, n_a} = sh_res;
        if (op == OP_ASL) n_ovf = sh_ovf;
        else if (op == OP_ASR) n_ovf = 1'b0;
      end
      ST_DVW: if (dv_done) begin
        fin   = 1'b1;
        n_a   = q_sgn;
        n_b   = r_sgn;
        n_ovf = q_ovf;
      end
      default: n_state = ST_IDLE;
    endcase
    if (fin) n_state = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      c_instr   <= '0;
      c_a       <= '0;
      c_b       <= '0;
      c_m0      <= '0;
      c_m1      <= '0;
      c_addr    <= '0;
      c_ovf     <= 1'b0;
      c_present <= 1'b0;
      c_newer   <= 1'b0;
      done_o    <= 1'b0;
      a_o       <= '0;
      b_o       <= '0;
      ovf_o     <= 1'b0;
      repeat_o  <= 1'b0;
      undef_o   <= 1'b0;
      store_o   <= 1'b0;
    end else begin
      state    <= n_state;
      done_o   <= fin;
      repeat_o <= n_rep;
      undef_o  <= n_undef;
      store_o  <= n_store;
      if (state == ST_IDLE && start_i) begin
        c_instr   <= instr_i;
        c_a       <= a_i;
        c_b       <= b_i;
        c_m0      <= mem0_i;
        c_m1      <= mem1_i;
        c_addr    <= addr_i;
        c_ovf     <= ovf_i;
        c_present <= present_i;
        c_newer   <= newer_i;
      end
      if (fin) begin
        a_o   <= n_a;
        b_o   <= n_b;
        ovf_o <= n_ovf;
      end
    end
  end

  assign st_addr0_o = c_addr;
  assign st_addr1_o = c_addr + AW'(1);
  assign st_data0_o = c_a;
  assign st_data1_o = c_b;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
  AST_STROBE_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || repeat_o || undef_o) |-> done_o); // R13
  AST_REPEAT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repeat_o |-> (b_o != '0)); // R10
  AST_UNDEF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (a_o == c_a && b_o == c_b && ovf_o == c_ovf)); // R12
  AST_ABSENT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !c_present) |-> (!store_o && !repeat_o && !undef_o
                                && a_o == c_a && b_o == c_b && ovf_o == c_ovf)); // R1
  AST_SHIFT_HAS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_done |=> done_o); // R13
endmodule

// File: tb/sim_xarith_ctrl.sv
`timescale 1ns/1ps
module sim_xarith_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, a_in = '0, b_in = '0, m0 = '0, m1 = '0;
  logic [14:0] addr = '0;
  logic        ovf_in = 1'b0, present = 1'b0, newer = 1'b0;
  logic        done, ovf_out, rep, undef, store;
  logic [15:0] a_out, b_out, sd0, sd1;
  logic [14:0] sa0, sa1;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xarith_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .a_i(a_in), .b_i(b_in), .mem0_i(m0), .mem1_i(m1), .addr_i(addr),
    .ovf_i(ovf_in), .present_i(present), .newer_i(newer),
    .done_o(done), .a_o(a_out), .b_o(b_out), .ovf_o(ovf_out),
    .repeat_o(rep), .undef_o(undef), .store_o(store),
    .st_addr0_o(sa0), .st_data0_o(sd0), .st_addr1_o(sa1), .st_data1_o(sd1)
  );

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'hC3A5, 16'h00F0};

  task automatic shift_model(input int k, input int n, input logic [31:0] v,
                             input logic oi, output logic [31:0] r, output logic o);
    logic [31:0] mask;
    o = oi;
    case (k)
      0: begin
        mask = (32'hFFFF_FFFF << (31 - n)) & 32'h7FFF_FFFF;
        o = v[31] ? ((~v & mask) != 0) : ((v & mask) != 0);
        r = ((v << n) & 32'h7FFF_FFFF) | (v & 32'h8000_0000);
      end
      1: r = v << n;
      2: r = (v << n) | (v >> (32 - n));
      3: begin r = 32'($signed(v) >>> n); o = 1'b0; end
      4: r = v >> n;
      default: r = (v >> n) | (v << (32 - n));
    endcase
  endtask

  task automatic model(input logic [15:0] ins, a, b, mw0, mw1, input logic oi, pr, nw,
                       output logic [15:0] ea, eb, output logic eo, es, er, eu);
    logic [7:0]  g;
    logic [3:0]  s;
    int          n;
    logic [31:0] r32, mag, q32, rr32, prod;
    logic [15:0] v2, q16;
    logic        rs, qs, o1;
    g = ins[15:8]; s = ins[7:4];
    n = (ins[3:0] == 0) ? 16 : int'(ins[3:0]);
    ea = a; eb = b; eo = oi; es = 0; er = 0; eu = 0;
    prod = 32'($signed(a) * $signed(mw0));
    if (!pr) return;
    case (g)
      8'o200: case (s)
        4'o00: eu = !nw;
        4'o01: begin shift_model(0, n, {b, a}, oi, r32, o1); {eb, ea} = r32; eo = o1; end
        4'o02: begin shift_model(1, n, {b, a}, oi, r32, o1); {eb, ea} = r32; eo = o1; end
        4'o04: begin shift_model(2, n, {b, a}, oi, r32, o1); {eb, ea} = r32; eo = o1; end
        4'o03: if (nw) begin eb = b + 16'd1; er = (eb != 0); end
               else begin {eb, ea} = prod; eo = 0; end
        4'o10: begin {eb, ea} = prod; eo = 0; end
        default: eu = 1;
      endcase
      8'o202: case (s)
        4'o01: begin shift_model(3, n, {b, a}, oi, r32, o1); {eb, ea} = r32; eo = o1; end
        4'o02: begin shift_model(4, n, {b, a}, oi, r32, o1); {eb, ea} = r32; eo = o1; end
        4'o04: begin shift_model(5, n, {b, a}, oi, r32, o1); {eb, ea} = r32; eo = o1; end
        default: eu = 1;
      endcase
      8'o201: begin
        rs  = b[15];
        qs  = b[15] ^ mw0[15];
        mag = rs ? -{b, a} : {b, a};
        v2  = mw0[15] ? -mw0 : mw0;
        if (mag[31:16] >= v2) eo = 1;
        else begin
          q32  = mag / {16'h0, v2};
          rr32 = mag % {16'h0, v2};
          q16  = q32[15:0];
          eo   = 0;
          if (q16 != 0) begin
            if (qs) q16 = -q16;
            eo = q16[15] ^ qs;
          end
          ea = q16;
          eb = rs ? -rr32[15:0] : rr32[15:0];
        end
      end
      8'o210: begin ea = mw0; eb = mw1; end
      8'o211: es = 1;
      default: eu = 1;
    endcase
  endtask

  task automatic apply(input logic [15:0] ins, a, b, mw0, mw1, input logic [14:0] adr,
                       input logic oi, pr, nw, input string tag);
    logic [15:0] ea, eb;
    logic        eo, es, er, eu, bad, seen;
    model(ins, a, b, mw0, mw1, oi, pr, nw, ea, eb, eo, es, er, eu);
    @(negedge clk);
    instr = ins; a_in = a; b_in = b; m0 = mw0; m1 = mw1; addr = adr;
    ovf_in = oi; present = pr; newer = nw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 64 && !seen; i++) begin
      @(negedge clk);
      seen = done;
    end
    n_vec++;
    bad = !seen || a_out !== ea || b_out !== eb || ovf_out !== eo ||
          store !== es || rep !== er || undef !== eu;
    if (es) bad = bad || sa0 !== adr || sa1 !== 15'(adr + 15'd1) ||
                  sd0 !== a || sd1 !== b;
    if (bad) begin
      n_bad++;
      $display("FAIL %s instr=%o a=%h b=%h m=%h: got done=%b a=%h b=%h o=%b st=%b rp=%b ud=%b sa=%h/%h exp a=%h b=%h o=%b st=%b rp=%b ud=%b sa=%h",
               tag, ins, a, b, mw0, seen, a_out, b_out, ovf_out, store, rep, undef,
               sa0, sa1, ea, eb, eo, es, er, eu, adr);
    end
    @(negedge clk);
    n_vec++;
    if (done !== 1'b0 || store !== 1'b0 || rep !== 1'b0 || undef !== 1'b0) begin
      n_bad++;
      $display("FAIL R13 strobe held past completion: done=%b st=%b rp=%b ud=%b exp 0",
               done, store, rep, undef);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired: got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] sh_codes [6];
    sh_codes = '{16'o100020, 16'o100040, 16'o100100, 16'o101020, 16'o101040, 16'o101100};
    #12 rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (done !== 0 || a_out !== 0 || b_out !== 0 || ovf_out !== 0 ||
        rep !== 0 || undef !== 0 || store !== 0) begin
      n_bad++;
      $display("FAIL R13 reset state: got done=%b a=%h b=%h o=%b exp all zero",
               done, a_out, b_out, ovf_out);
    end

    // R1: unit absent
    foreach (sh_codes[k]) apply(sh_codes[k], 16'h1234, 16'h8001, 16'h5, 16'h6, 15'h10, 1'b1, 1'b0, 1'b1, "R1");
    apply(16'o100200, 16'h0003, 16'h0000, 16'h0004, 0, 0, 1'b1, 1'b0, 1'b1, "R1");
    apply(16'o100060, 16'h0003, 16'h0010, 0, 0, 0, 1'b0, 1'b0, 1'b1, "R1");
    apply(16'o104400, 16'hAAAA, 16'h5555, 0, 0, 15'h7FFF, 1'b0, 1'b0, 1'b1, "R1");
    apply(16'o177777, 16'hAAAA, 16'h5555, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R1");

    // R2 R3 R4: every shift kind, every count field, several operands
    foreach (sh_codes[k])
      for (int c = 0; c < 16; c++)
        for (int v = 0; v < 8; v++)
          apply(sh_codes[k] | 16'(c), vals[v], vals[7 - v], 0, 0, 0, 1'(v & 1), 1'b1, 1'b1,
                (k < 3) ? "R3 R2" : "R4 R2");

    // R5 and R11: multiply and the older-model delay code
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        apply(16'o100200, vals[i], 16'hBEEF, vals[j], 0, 0, 1'b1, 1'b1, 1'b1, "R5");
        apply(16'o100060, vals[i], 16'h0042, vals[j], 0, 0, 1'b1, 1'b1, 1'b0, "R11");
      end

    // R6 R7: divide sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 3; k++)
          apply(16'o100400, vals[i], (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : vals[j] >> 2,
                vals[j], 0, 0, 1'(k == 2), 1'b1, 1'b1, "R6 R7");
    apply(16'o100400, 16'h0064, 16'h0000, 16'h0007, 0, 0, 1'b0, 1'b1, 1'b1, "R6");
    apply(16'o100400, 16'hFF9C, 16'hFFFF, 16'h0007, 0, 0, 1'b0, 1'b1, 1'b1, "R6");
    apply(16'o100400, 16'h0000, 16'h4000, 16'h7FFF, 0, 0, 1'b0, 1'b1, 1'b1, "R6");
    apply(16'o100400, 16'h0000, 16'h0000, 16'h0000, 0, 0, 1'b0, 1'b1, 1'b1, "R7");
    apply(16'o100400, 16'h1111, 16'h0009, 16'h0009, 0, 0, 1'b0, 1'b1, 1'b1, "R7");

    // R8 R9: double load and store, including address wrap
    apply(16'o104200, 16'h1111, 16'h2222, 16'hABCD, 16'h0123, 0, 1'b1, 1'b1, 1'b1, "R8");
    apply(16'o104277, 16'h1111, 16'h2222, 16'h8000, 16'hFFFF, 0, 1'b0, 1'b1, 1'b0, "R8");
    apply(16'o104400, 16'hCAFE, 16'hF00D, 0, 0, 15'h7FFF, 1'b0, 1'b1, 1'b1, "R9");
    apply(16'o104400, 16'h0001, 16'h0002, 0, 0, 15'h1234, 1'b1, 1'b1, 1'b0, "R9");

    // R10: delay counter repeat and wrap
    foreach (vals[v]) apply(16'o100060, 16'h5A5A, vals[v], 0, 0, 0, 1'(v & 1), 1'b1, 1'b1, "R10");
    apply(16'o100060, 16'h0000, 16'hFFFE, 0, 0, 0, 1'b0, 1'b1, 1'b1, "R10");

    // R12: all sub-ops of both shift groups on both models, plus foreign groups
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++) begin
        apply(16'o100000 | 16'(s << 4) | 16'd5, 16'h0F0F, 16'h8421, 16'h3, 0, 0, 1'(m), 1'b1, 1'(m), "R12");
        apply(16'o101000 | 16'(s << 4) | 16'd5, 16'h0F0F, 16'h8421, 16'h3, 0, 0, 1'(m), 1'b1, 1'(m), "R12");
      end
    apply(16'o101400, 16'h1, 16'h2, 0, 0, 0, 1'b1, 1'b1, 1'b1, "R12");
    apply(16'o000000, 16'h1, 16'h2, 0, 0, 0, 1'b0, 1'b1, 1'b1, "R12");
    apply(16'o105000, 16'h1, 16'h2, 0, 0, 0, 1'b0, 1'b1, 1'b0, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule